// File: doc/BRIEF.md
# MII Receive Inter-Frame Gap Gate

This block sits on the receive side of an Ethernet path, between the store that holds decoded frames and the state machine that clocks them out on the MII receive bus. It holds back the start of the next frame until a minimum number of idle MII clock cycles has gone by since the last frame ended. The transmit state machine reads a single permit output and starts a new frame only while that permit is high.

Two gap lengths can be programmed: a normal gap and a shorter low gap. When a frame ends, the block compares the buffer's byte count with a programmable watermark. If the count is strictly above the watermark, the low gap is used so that the backlog drains faster. Otherwise the normal gap is used. Both the choice and the gap length are captured at end of frame, so a countdown already running cannot be changed partway through. A programmed gap of zero is rounded up to one idle cycle.

Top module: `mii_rx_gap_gate`

## Requirements
- R1: After reset `send_ok` is 1 and `low_gap_sel` is 0, so the normal gap is selected.
- R2: When `frame_end` is high in cycle E and the normal gap G is selected, `send_ok` is 0 in cycles E+1 through E+G and returns to 1 in cycle E+G+1.
- R3: If `fifo_fill` is strictly greater than `watermark` in the `frame_end` cycle, the following gap uses `gap_low` and `low_gap_sel` reads 1 from the next cycle.
- R4: If `fifo_fill` equals `watermark` in the `frame_end` cycle, the normal gap is used and `low_gap_sel` reads 0.
- R5: Once the low gap has been selected, a later `frame_end` with `fifo_fill` at or below `watermark` returns the selection to the normal gap.
- R6: A selected gap value of zero gives exactly one idle cycle, with `send_ok` low only in cycle E+1.
- R7: Changes to `fifo_fill`, `watermark`, `gap_normal` or `gap_low` while no `frame_end` is present change neither `low_gap_sel` nor the length of a countdown that is already running.
- R8: A `frame_end` that arrives during a countdown, including in its last idle cycle, restarts the countdown with the gap selected at that new `frame_end`. Apart from this, once `send_ok` is high it stays high until the next `frame_end`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | MII receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_fill | input | FILL_W | Number of bytes currently held in the receive buffer |
| watermark | input | FILL_W | Fill level above which the low gap is chosen |
| gap_normal | input | GAP_W | Normal minimum idle cycles |
| gap_low | input | GAP_W | Reduced minimum idle cycles |
| frame_end | input | 1 | High on the last data cycle of a frame |
| send_ok | output | 1 | High when a new frame may start this cycle |
| low_gap_sel | output | 1 | Gap choice made at the most recent frame end (1 = low) |

## Verification
Two events can fall in the same cycle: a new end-of-frame and the last idle cycle of a running countdown. The bench provokes this by raising `frame_end` in exactly the last cycle in which `send_ok` is still low. The correct result is that the expiry is discarded and a new countdown of the newly chosen length starts, so `send_ok` must stay low without a one-cycle high glitch and then stay low for exactly the new gap. A second case changes the gap values and the fill level during a countdown, and checks that the count in progress and the reported selection both keep the values captured at end of frame.

// File: rtl/mii_rx_gap_gate.sv
module mii_rx_gap_gate #(
  parameter int FILL_W = 12,
  parameter int GAP_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] fifo_fill,
  input  logic [FILL_W-1:0] watermark,
  input  logic [GAP_W-1:0]  gap_normal,
  input  logic [GAP_W-1:0]  gap_low,
  input  logic              frame_end,
  output logic              send_ok,
  output logic              low_gap_sel
);

  localparam logic [GAP_W-1:0] ONE = GAP_W'(1);

  logic             busy;
  logic [GAP_W-1:0] idle_cnt;
  logic [GAP_W-1:0] target;

  wire              above    = fifo_fill > watermark;
  wire [GAP_W-1:0]  pick     = above ? gap_low : gap_normal;
  wire [GAP_W-1:0]  pick_min = (pick == '0) ? ONE : pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      idle_cnt    <= '0;
      target      <= ONE;
      low_gap_sel <= 1'b0;
    end else if (frame_end) begin
      busy        <= 1'b1;
      idle_cnt    <= ONE;
      target      <= pick_min;
      low_gap_sel <= above;
    end else if (busy) begin
      if (idle_cnt >= target) busy <= 1'b0;
      else                    idle_cnt <= idle_cnt + ONE;
    end
  end

  assign send_ok = ~busy;

  // R2: a frame end always withholds the permit in the next cycle
  assert_hold_after_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !send_ok);

  // R3: fill above watermark at frame end selects the low gap
  assert_low_when_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && (fifo_fill > watermark)) |=> low_gap_sel);

  // R4 and R5: fill at or below watermark at frame end selects the normal gap
  assert_normal_when_not_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !(fifo_fill > watermark)) |=> !low_gap_sel);

  // R7: the selection changes only at a frame end
  assert_sel_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(low_gap_sel));

  // R8: a granted permit persists until the next frame end
  assert_permit_persists_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (send_ok && !frame_end) |=> send_ok);

endmodule

// File: tb/tb_mii_rx_gap_gate.sv
module tb_mii_rx_gap_gate;
  localparam int FILL_W = 12;
  localparam int GAP_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [FILL_W-1:0] fifo_fill;
  logic [FILL_W-1:0] watermark;
  logic [GAP_W-1:0]  gap_normal;
  logic [GAP_W-1:0]  gap_low;
  logic              frame_end;
  logic              send_ok;
  logic              low_gap_sel;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  mii_rx_gap_gate #(.FILL_W(FILL_W), .GAP_W(GAP_W)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_fill(fifo_fill), .watermark(watermark),
    .gap_normal(gap_normal), .gap_low(gap_low), .frame_end(frame_end),
    .send_ok(send_ok), .low_gap_sel(low_gap_sel)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks = checks + 1;
    if (actual != expected) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic end_frame(input int fill, input int wm, input int gn, input int gl);
    @(negedge clk);
    fifo_fill  = FILL_W'(fill);
    watermark  = FILL_W'(wm);
    gap_normal = GAP_W'(gn);
    gap_low    = GAP_W'(gl);
    frame_end  = 1'b1;
    @(negedge clk);
    frame_end  = 1'b0;
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!send_ok && n < 40) begin
      n = n + 1;
      @(negedge clk);
    end
  endtask

  // fill, watermark, normal gap, low gap, expected idle cycles, expected selection
  localparam int NV = 10;
  localparam logic [40:0] VEC [NV] = '{
    {12'd10,   12'd100,  5'd12, 5'd4,  6'd12, 1'b0},  // R2
    {12'd101,  12'd100,  5'd12, 5'd4,  6'd4,  1'b1},  // R3
    {12'd100,  12'd100,  5'd12, 5'd4,  6'd12, 1'b0},  // R4
    {12'd200,  12'd100,  5'd9,  5'd2,  6'd2,  1'b1},  // R3
    {12'd50,   12'd100,  5'd9,  5'd2,  6'd9,  1'b0},  // R5
    {12'd10,   12'd100,  5'd0,  5'd3,  6'd1,  1'b0},  // R6
    {12'd300,  12'd100,  5'd7,  5'd0,  6'd1,  1'b1},  // R6
    {12'd4095, 12'd4094, 5'd31, 5'd31, 6'd31, 1'b1},  // R3
    {12'd0,    12'd0,    5'd31, 5'd3,  6'd31, 1'b0},  // R4
    {12'd1,    12'd0,    5'd5,  5'd6,  6'd6,  1'b1}   // R3
  };

  initial begin
    int n;
    rst_n = 1'b0; frame_end = 1'b0;
    fifo_fill = '0; watermark = '0; gap_normal = 5'd12; gap_low = 5'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 send_ok after reset", int'(send_ok), 1);
    check("R1 low_gap_sel after reset", int'(low_gap_sel), 0);

    for (int i = 0; i < NV; i++) begin
      end_frame(int'(VEC[i][40:29]), int'(VEC[i][28:17]),
                int'(VEC[i][16:12]), int'(VEC[i][11:7]));
      check($sformatf("R2/R3/R4/R5/R6 vec%0d selection", i),
            int'(low_gap_sel), int'(VEC[i][0]));
      count_low(n);
      check($sformatf("R2/R3/R4/R5/R6 vec%0d gap", i), n, int'(VEC[i][6:1]));
      repeat (2) @(negedge clk);
      check($sformatf("R8 vec%0d permit holds", i), int'(send_ok), 1);
    end

    // R7: changes mid-countdown are ignored
    end_frame(10, 100, 10, 2);
    gap_normal = 5'd2; fifo_fill = 12'd4000; gap_low = 5'd1;
    count_low(n);
    check("R7 countdown keeps captured gap", n, 10);
    check("R7 selection unchanged", int'(low_gap_sel), 0);
    repeat (2) @(negedge clk);

    // R8: frame end in the final idle cycle restarts the countdown
    end_frame(10, 100, 5, 2);
    repeat (4) @(negedge clk);
    check("R8 still withheld in last idle cycle", int'(send_ok), 0);
    fifo_fill = 12'd10; gap_normal = 5'd3; frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    check("R8 no permit glitch on restart", int'(send_ok), 0);
    count_low(n);
    check("R8 restarted gap length", n, 3);

    // R8 and R3: restart mid-countdown with low gap
    end_frame(10, 100, 20, 2);
    repeat (3) @(negedge clk);
    fifo_fill = 12'd500; frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    check("R3 restart picks low gap", int'(low_gap_sel), 1);
    count_low(n);
    check("R8 restart mid-countdown length", n, 2);

    // R1: reset during a countdown restores defaults
    end_frame(500, 100, 20, 9);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 send_ok after mid-gap reset", int'(send_ok), 1);
    check("R1 selection after mid-gap reset", int'(low_gap_sel), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule